// File: doc/BRIEF.md
# Shadowed PWM Generator

A single-channel pulse-width modulator clocked from a fixed 1 MHz reference. A 2-bit prescaler code sets how many reference clocks make up one count step. Software writes the prescaler code, the high-time (duty) and the period length through a plain register-write port. None of these writes touches the waveform that is already running.

Writing the period register arms the staged settings. They are copied into the active set in one step, at the end of the period that is running. A period value of zero stops the output: the running period finishes, and after that the pin stays low. While the block is idle with a zero period, an armed non-zero setting starts at once, without waiting for a boundary. A pending flag on a port shows that an armed setting has not been loaded yet.

Top module: `shadow_pwm`

## Requirements
- R1: The prescaler code is `wr_data[1:0]` written to address 2. Code 0, 1, 2 or 3 makes each count step last 1, 2, 4 or 8 reference clocks.
- R2: Writes to duty (address 1) and prescaler (address 2) leave the output unchanged until a write to the period register (address 0) commits them.
- R3: A committed setting takes effect only when the running period ends. Every period runs with one complete setting, all old or all new.
- R4: Within a period, the output is high while the step count is below duty and low for the rest. Duty 0 gives a constant low output. Duty of at least the period gives a constant high output.
- R5: An active period of zero holds the output low. Committing zero lets the running period finish first.
- R6: When the active period is zero, a commit loads on the next clock. The first step of the new period shows on `pwm_out` one clock after the load.
- R7: `pend` rises on the clock after a period write. It falls on the clock after the staged setting is loaded.
- R8: A synchronous reset clears the staging and active registers, drives `pwm_out` low and clears `pend`.
- R9: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty, 2 prescaler, 3 unused |
| wr_data | input | 16 | Write data |
| pend | output | 1 | A committed setting has not been loaded yet |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench sweeps every prescaler code against small periods and duties, including duty zero and duty above the period. A wrong divider or compare shows up there as wrong high and low lengths. It commits new settings partway through a period. A design that loads early would produce a period that is shortened or that mixes old and new settings. It also writes duty and prescaler with no commit, and writes to the unused address; a leaking staging path would change the waveform. Disabling partway through checks that the output neither drops before the period ends nor rises after it, and a commit from idle checks that the first period is not delayed to a boundary that never comes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PRESC  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_stage.sv
module pwm_stage #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load_i,
  output logic [CNT_W-1:0] st_period,
  output logic [CNT_W-1:0] st_duty,
  output logic [PSC_W-1:0] st_psc,
  output logic             pend
);
  import pwm_pkg::*;

  logic hit_period, hit_duty, hit_psc;
  assign hit_period = wr_en && (wr_addr == SEL_PERIOD);
  assign hit_duty   = wr_en && (wr_addr == SEL_DUTY);
  assign hit_psc    = wr_en && (wr_addr == SEL_PRESC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_period <= '0;
      st_duty   <= '0;
      st_psc    <= '0;
      pend      <= 1'b0;
    end else begin
      if (hit_period) st_period <= wr_data;
      if (hit_duty)   st_duty   <= wr_data;
      if (hit_psc)    st_psc    <= wr_data[PSC_W-1:0];
      if (hit_period)  pend <= 1'b1;
      else if (load_i) pend <= 1'b0;
    end
  end

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
    hit_period |=> pend);
  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && !hit_period) |=> !pend);
endmodule

// File: rtl/pwm_tick.sv
module pwm_tick #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] lim;

  assign lim    = DIV_W'((32'd1 << psc_i) - 32'd1);
  assign tick_o = !hold_i && (div_cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i || hold_i) div_cnt <= '0;
    else if (tick_o)            div_cnt <= '0;
    else                        div_cnt <= div_cnt + 1'b1;
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_o && psc_i != '0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] st_period,
  input  logic [CNT_W-1:0] st_duty,
  input  logic [PSC_W-1:0] st_psc,
  output logic             load_o,
  output logic             pwm_out
);
  logic [CNT_W-1:0] act_period, act_duty, cnt;
  logic [PSC_W-1:0] act_psc;
  logic             idle, tick, at_end;

  assign idle   = (act_period == '0);
  assign at_end = tick && (cnt == act_period - CNT_W'(1));
  assign load_o = pend_i && (idle || at_end);

  pwm_tick #(.PSC_W(PSC_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clr_i (load_o),
    .hold_i(idle),
    .psc_i (act_psc),
    .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_period <= '0;
      act_duty   <= '0;
      act_psc    <= '0;
      cnt        <= '0;
      pwm_out    <= 1'b0;
    end else begin
      pwm_out <= !idle && (cnt < act_duty);
      if (load_o) begin
        act_period <= st_period;
        act_duty   <= st_duty;
        act_psc    <= st_psc;
        cnt        <= '0;
      end else if (tick) begin
        cnt <= at_end ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    idle |=> !pwm_out);
  assert_atomic_R3: assert property (@(posedge clk) disable iff (rst)
    !pend_i |=> ($stable(act_period) && $stable(act_duty) && $stable(act_psc)));
  assert_duty_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0) |=> !pwm_out);
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (cnt < act_period));
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pend,
  output logic             pwm_out
);
  logic [CNT_W-1:0] st_period, st_duty;
  logic [PSC_W-1:0] st_psc;
  logic             load;

  pwm_stage #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_i   (load),
    .st_period(st_period),
    .st_duty  (st_duty),
    .st_psc   (st_psc),
    .pend     (pend)
  );

  pwm_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend),
    .st_period(st_period),
    .st_duty  (st_duty),
    .st_psc   (st_psc),
    .load_o   (load),
    .pwm_out  (pwm_out)
  );

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!pwm_out && !pend));
endmodule

// File: tb/sim_shadow_pwm.sv
module sim_shadow_pwm;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pend, pwm_out;

  int n_run = 0, n_fail = 0;
  bit chk_en = 1'b0;
  string cur_req = "R8";

  shadow_pwm u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pend(pend), .pwm_out(pwm_out));

  always #(CLK_P/2) clk = ~clk;

  // Behavioural model in reference-clock positions within a period.
  int m_per, m_duty, m_div, m_pos, s_per, s_duty, s_psc;
  bit m_out, m_pend;

  always @(posedge clk) begin
    if (rst) begin
      m_per = 0; m_duty = 0; m_div = 1; m_pos = 0;
      s_per = 0; s_duty = 0; s_psc = 0; m_out = 0; m_pend = 0;
    end else begin
      bit ld;
      m_out = (m_per != 0) && (m_pos < m_duty * m_div);
      ld = m_pend && (m_per == 0 || m_pos == m_per * m_div - 1);
      if (ld) begin
        m_per = s_per; m_duty = s_duty; m_div = 1 << s_psc; m_pos = 0;
      end else if (m_per != 0) begin
        m_pos = (m_pos == m_per * m_div - 1) ? 0 : m_pos + 1;
      end
      if (wr_en && wr_addr == 2'd0) m_pend = 1;
      else if (ld) m_pend = 0;
      if (wr_en && wr_addr == 2'd0) s_per = wr_data;
      if (wr_en && wr_addr == 2'd1) s_duty = wr_data;
      if (wr_en && wr_addr == 2'd2) s_psc = wr_data[1:0];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(cur_req, "pwm_out", int'(pwm_out), int'(m_out));
      check(cur_req, "pend", int'(pend), int'(m_pend));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    while (pend) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 180000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R8";
    check("R8", "pwm_out after reset", int'(pwm_out), 0);
    check("R8", "pend after reset", int'(pend), 0);
    chk_en = 1'b1;

    // R5: idle with zero period stays low
    cur_req = "R5"; cycles(10);
    check("R5", "idle low", int'(pwm_out), 0);

    // R6/R7: commit from idle, explicit timing
    cur_req = "R6";
    wr(1, 3); wr(2, 0);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 5;
    @(negedge clk); wr_en = 0;
    check("R7", "pend after period write", int'(pend), 1);
    @(negedge clk);
    check("R7", "pend after idle load", int'(pend), 0);
    check("R6", "first step not yet shown", int'(pwm_out), 0);
    @(negedge clk);
    check("R6", "first step high", int'(pwm_out), 1);
    cycles(20);

    // R1/R4: sweep prescaler, period, duty
    for (int p = 0; p < 4; p++)
      for (int per = 1; per <= 4; per++)
        for (int d = 0; d <= 5; d++) begin
          cur_req = (p == 0) ? "R4" : "R1";
          wr(1, d); wr(2, p); wr(0, per);
          settle();
          cycles(2 * per * (1 << p) + 3);
        end

    // R2: staged writes without commit
    cur_req = "R2";
    wr(1, 6); wr(2, 1); wr(0, 10); settle(); cycles(7);
    wr(1, 1); wr(2, 3);
    cycles(80);
    check("R2", "pend stays low without commit", int'(pend), 0);

    // R3: commit mid-period, then back-to-back commits
    cur_req = "R3";
    cycles(5); wr(0, 3);
    cycles(60);
    wr(1, 2); wr(2, 0); cycles(3); wr(0, 7); wr(1, 5); wr(0, 9);
    cycles(60);

    // R4: duty above period gives constant high
    cur_req = "R4";
    wr(1, 50); wr(2, 2); wr(0, 4); settle(); cycles(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R4", "duty over period high", int'(pwm_out), 1);
    end

    // R5: disable mid-period
    cur_req = "R5";
    wr(1, 4); wr(2, 1); wr(0, 6); settle(); cycles(5);
    wr(0, 0);
    cycles(40);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R5", "low after disable", int'(pwm_out), 0);
    end

    // R9: unused address ignored
    cur_req = "R9";
    wr(1, 2); wr(2, 0); wr(0, 4); settle(); cycles(6);
    wr(3, 16'hffff); wr(3, 0);
    check("R9", "pend after unused write", int'(pend), 0);
    cycles(30);

    // R8: reset mid-run
    cur_req = "R8";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8", "pwm_out after mid reset", int'(pwm_out), 0);
    check("R8", "pend after mid reset", int'(pend), 0);
    cycles(20);

    chk_en = 1'b0;
    finish_up();
  end
endmodule